// File: doc/BRIEF.md
# Bit Error Rate Measurement Counters with Event Status

This block collects the raw numbers a bit error rate tester needs and tells a host when something worth attention has happened. Two running counters accumulate received bits and errored bits while the receive synchronizer reports lock. The host picks the integration period. A rising edge on a latch request copies both running totals into readable holding registers and restarts the running counts in the same cycle. The latch request comes from either an input pin or a control bit. The host then divides the error total by the bit total.

A status register gathers events and conditions: counter overflow, detected errors, loss of lock, and long runs of ones or zeros. Events stay latched until the host reads them. Conditions stay set for as long as they last. A mask register picks which status bits pull the active-low interrupt. The host reaches everything through a simple synchronous port with a read strobe, a write strobe, a 4-bit address and byte-wide data.

Top module: `ber_meas_top`

## Requirements
- R1: Synchronous reset clears both running counters, both holding registers, the status bits, the mask and the control bit. During and right after reset, `host_rdata` is 0 and `irq_n` is high.
- R2: The bit counter adds one in each cycle where `bit_vld` and `sync_in` are both high. The error counter adds one in each cycle where `bit_vld`, `err_pulse` and `sync_in` are all high. Neither counter moves while `sync_in` is low.
- R3: The latch request is `latch_pin` OR control bit 0 at address 0x0. On its rising edge, both running counts are copied into the holding registers and the running counts restart. A bit or error counted in the edge cycle is the first of the new period. The bit-count holding bytes read at 0x4..0x7 and the error-count holding bytes at 0x8..0xB, least significant byte at the lower address. Bytes above the counter width read 0.
- R4: The holding registers change only on a latch edge. A latch request held high for many cycles causes exactly one capture.
- R5: When a running counter at its all-ones value counts again, it wraps to 0. The wrap sets status bit 2 for the bit counter or status bit 1 for the error counter.
- R6: Each counted error sets status bit 3.
- R7: Status reads at 0x2. Bit 6 means all-ones is present, bit 5 all-zeros, bit 4 loss of lock, bit 3 error seen, bits 2 and 1 overflow, and bit 0 is the live value of `sync_in`. Bit 7 reads 0. Bit 4 is set in every cycle in which `sync_in` is low.
- R8: A status read clears, one cycle later, the latched bits it returned as 1. A bit whose condition or event is present in that clearing cycle stays set, so bits 6, 5 and 4 persist while their condition lasts. A bit that became set after the read's snapshot is not cleared.
- R9: The mask reads and writes at 0x1. `irq_n` is low exactly when some status bit 6..0 (including the live bit 0) is 1 and its mask bit is 1. With a zero mask, `irq_n` stays high.
- R10: `host_rdata` is loaded one cycle after `host_rd` and holds otherwise. Writes to read-only or unused addresses change nothing. Unused addresses (such as 0x3) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-side clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Synchronizer lock indication |
| bit_vld | input | 1 | A received bit is present this cycle |
| err_pulse | input | 1 | The bit this cycle was in error |
| all_ones | input | 1 | Synchronizer sees a long run of ones |
| all_zeros | input | 1 | Synchronizer sees a long run of zeros |
| latch_pin | input | 1 | External latch request, ORed with control bit 0 |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with an 8-bit counter width instead of the default 32. With that width, a wrap of either running counter takes only 256 counted bits, so overflow flags, wrap-to-zero and reads of holding bytes above the counter width can all be reached in a short run. The remaining checks cover the clear-on-read rules under persisting conditions, an error that arrives in the very cycle of a status read, and interrupt masking. None of these depends on the counter width.

// File: rtl/ber_meas_pkg.sv
package ber_meas_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int EXT_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_MASK = 4'h1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h2;
    localparam logic [1:0]        BANK_BC = 2'd1;
    localparam logic [1:0]        BANK_EC = 2'd2;

    localparam int ST_SYNC = 0;
    localparam int ST_LOS  = 4;

    // latched part of the status word, bits 6..1
    typedef struct packed {
        logic ones;
        logic zeros;
        logic los;
        logic err;
        logic bc_ovf;
        logic ec_ovf;
    } stat_ev_t;

    localparam int NSTAT = $bits(stat_ev_t);

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [EXT_W-1:0] v,
                                                    input logic [1:0] idx);
        return v[idx*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/ber_run_counter.sv
module ber_run_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         snap_i,
    output logic [W-1:0] run_o,
    output logic [W-1:0] hold_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic [W-1:0] run_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            hold_q <= '0;
        end else if (snap_i) begin
            hold_q <= run_q;
            run_q  <= inc_i ? W'(1) : '0;
        end else if (inc_i) begin
            run_q <= run_q + W'(1);
        end
    end

    // a wrap only when not restarted by a capture in the same cycle
    assign ovf_o  = inc_i & ~snap_i & (run_q == ALL1);
    assign run_o  = run_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/ber_stat_latch.sv
module ber_stat_latch
    import ber_meas_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  stat_ev_t set_i,
    input  logic     clr_en_i,
    input  stat_ev_t clr_sel_i,
    output stat_ev_t stat_o
);
    logic [NSTAT-1:0] set_v;
    logic [NSTAT-1:0] sel_v;
    logic [NSTAT-1:0] st_q;

    assign set_v = set_i;
    assign sel_v = clr_sel_i;

    for (genvar i = 0; i < NSTAT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                st_q[i] <= 1'b0;
            else
                st_q[i] <= set_v[i] | (st_q[i] & ~(clr_en_i & sel_v[i]));
        end
    end

    assign stat_o = st_q;
endmodule

// File: rtl/ber_host_port.sv
module ber_host_port
    import ber_meas_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BYTE_W-1:0]   wdata_i,
    input  logic [EXT_W-1:0]    bc_hold_i,
    input  logic [EXT_W-1:0]    ec_hold_i,
    input  logic [BYTE_W-1:0]   stat_i,
    output logic                ctrl_latch_o,
    output logic [BYTE_W-1:0]   mask_o,
    output logic [BYTE_W-1:0]   rdata_o,
    output logic                clr_en_o,
    output logic [BYTE_W-1:0]   clr_sel_o
);
    logic              ctrl_q;
    logic [BYTE_W-1:0] mask_q;
    logic [BYTE_W-1:0] rdata_q;
    logic              clr_en_q;
    logic [BYTE_W-1:0] clr_sel_q;
    logic [BYTE_W-1:0] rmux;

    always_comb begin
        rmux = '0;
        case (addr_i[3:2])
            BANK_BC: rmux = pick_byte(bc_hold_i, addr_i[1:0]);
            BANK_EC: rmux = pick_byte(ec_hold_i, addr_i[1:0]);
            2'd0: begin
                if (addr_i == A_CTRL)      rmux = {{(BYTE_W-1){1'b0}}, ctrl_q};
                else if (addr_i == A_MASK) rmux = mask_q;
                else if (addr_i == A_STAT) rmux = stat_i;
                else                       rmux = '0;
            end
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= 1'b0;
            mask_q    <= '0;
            rdata_q   <= '0;
            clr_en_q  <= 1'b0;
            clr_sel_q <= '0;
        end else begin
            if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i[0];
            if (wr_i && addr_i == A_MASK) mask_q <= wdata_i;
            if (rd_i) rdata_q <= rmux;
            clr_en_q <= rd_i && (addr_i == A_STAT);
            if (rd_i && addr_i == A_STAT) clr_sel_q <= stat_i;
        end
    end

    assign ctrl_latch_o = ctrl_q;
    assign mask_o       = mask_q;
    assign rdata_o      = rdata_q;
    assign clr_en_o     = clr_en_q;
    assign clr_sel_o    = clr_sel_q;
endmodule

// File: rtl/ber_meas_top.sv
module ber_meas_top
    import ber_meas_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_in,
    input  logic        bit_vld,
    input  logic        err_pulse,
    input  logic        all_ones,
    input  logic        all_zeros,
    input  logic        latch_pin,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [3:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        irq_n
);
    localparam int NCNT = 2;
    localparam int IBC  = 0;
    localparam int IEC  = 1;

    logic             ctrl_latch;
    logic             latch_req;
    logic             latch_prev_q;
    logic             latch_edge;
    logic [NCNT-1:0]  inc_v;
    logic [NCNT-1:0]  ovf_v;
    logic [CNT_W-1:0] run_v  [NCNT];
    logic [CNT_W-1:0] hold_v [NCNT];
    logic [CNT_W-1:0] bc_run;
    logic [CNT_W-1:0] bc_hold;
    logic [CNT_W-1:0] ec_hold;
    logic [EXT_W-1:0] bc_ext;
    logic [EXT_W-1:0] ec_ext;
    stat_ev_t         st_set;
    stat_ev_t         st_q;
    logic [7:0]       stat_vec;
    logic [7:0]       mask_q;
    logic             clr_en;
    logic [7:0]       clr_sel;

    assign latch_req  = latch_pin | ctrl_latch;
    assign latch_edge = latch_req & ~latch_prev_q;

    always_ff @(posedge clk) begin
        if (rst) latch_prev_q <= 1'b0;
        else     latch_prev_q <= latch_req;
    end

    assign inc_v[IBC] = bit_vld & sync_in;
    assign inc_v[IEC] = bit_vld & sync_in & err_pulse;

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        ber_run_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .inc_i  (inc_v[c]),
            .snap_i (latch_edge),
            .run_o  (run_v[c]),
            .hold_o (hold_v[c]),
            .ovf_o  (ovf_v[c])
        );
    end

    assign bc_run  = run_v[IBC];
    assign bc_hold = hold_v[IBC];
    assign ec_hold = hold_v[IEC];
    assign bc_ext  = EXT_W'(bc_hold);
    assign ec_ext  = EXT_W'(ec_hold);

    always_comb begin
        st_set        = '0;
        st_set.ones   = all_ones;
        st_set.zeros  = all_zeros;
        st_set.los    = ~sync_in;
        st_set.err    = inc_v[IEC];
        st_set.bc_ovf = ovf_v[IBC];
        st_set.ec_ovf = ovf_v[IEC];
    end

    ber_stat_latch u_stat (
        .clk       (clk),
        .rst       (rst),
        .set_i     (st_set),
        .clr_en_i  (clr_en),
        .clr_sel_i (stat_ev_t'(clr_sel[NSTAT:1])),
        .stat_o    (st_q)
    );

    assign stat_vec = {1'b0, st_q, sync_in};

    ber_host_port u_host (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (host_wr),
        .rd_i         (host_rd),
        .addr_i       (host_addr),
        .wdata_i      (host_wdata),
        .bc_hold_i    (bc_ext),
        .ec_hold_i    (ec_ext),
        .stat_i       (stat_vec),
        .ctrl_latch_o (ctrl_latch),
        .mask_o       (mask_q),
        .rdata_o      (host_rdata),
        .clr_en_o     (clr_en),
        .clr_sel_o    (clr_sel)
    );

    assign irq_n = ~|(stat_vec[6:0] & mask_q[6:0]);
endmodule

// File: rtl/ber_meas_chk.sv
module ber_meas_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_in,
    input logic             bit_vld,
    input logic             err_pulse,
    input logic             host_rd,
    input logic [3:0]       host_addr,
    input logic [7:0]       host_rdata,
    input logic             irq_n,
    input logic             latch_edge,
    input logic [CNT_W-1:0] bc_run,
    input logic [CNT_W-1:0] bc_hold,
    input logic [CNT_W-1:0] ec_hold,
    input logic [7:0]       stat_vec,
    input logic [7:0]       mask_q
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    assert_no_count_unsynced_R2: assert property (@(posedge clk) disable iff (rst)
        (!sync_in && !latch_edge) |=> $stable(bc_run));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        latch_edge |=> (bc_hold == $past(bc_run)));

    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (latch_edge && !(bit_vld && sync_in)) |=> (bc_run == '0));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !latch_edge |=> ($stable(bc_hold) && $stable(ec_hold)));

    assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && sync_in && !latch_edge && bc_run == ALL1) |=> (bc_run == '0 && stat_vec[2]));

    assert_err_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && sync_in && err_pulse) |=> stat_vec[3]);

    assert_los_set_R7: assert property (@(posedge clk) disable iff (rst)
        !sync_in |=> stat_vec[4]);

    assert_live_sync_read_R7: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 4'h2) |=> (host_rdata[0] == $past(sync_in)));

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mask_q[6:0] == 7'd0) |-> irq_n);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));
endmodule

bind ber_meas_top ber_meas_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sync_in    (sync_in),
    .bit_vld    (bit_vld),
    .err_pulse  (err_pulse),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .irq_n      (irq_n),
    .latch_edge (latch_edge),
    .bc_run     (bc_run),
    .bc_hold    (bc_hold),
    .ec_hold    (ec_hold),
    .stat_vec   (stat_vec),
    .mask_q     (mask_q)
);

// File: tb/ber_meas_top_tb_top.sv
module ber_meas_top_tb_top;
    localparam int TB_CNT_W = 8;
    localparam int NV = 32;
    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;

    // {op[29:28], flags{sync,vld,err,pin}[27:24], addr[23:20], data/count[19:12], expect[11:4], req[3:0]}
    localparam logic [29:0] VEC [NV] = '{
        {OP_IDLE, 4'b1100, 4'h0, 8'd10,  8'h00, 4'd2},   // R2 ten good bits
        {OP_IDLE, 4'b1110, 4'h0, 8'd3,   8'h00, 4'd2},   // R2 three errored bits
        {OP_IDLE, 4'b0110, 4'h0, 8'd5,   8'h00, 4'd2},   // R2 unsynced, ignored
        {OP_IDLE, 4'b1000, 4'h0, 8'd2,   8'h00, 4'd2},
        {OP_WR,   4'b1000, 4'h0, 8'h01,  8'h00, 4'd3},   // R3 latch via control bit
        {OP_IDLE, 4'b1000, 4'h0, 8'd1,   8'h00, 4'd3},
        {OP_RD,   4'b1000, 4'h4, 8'h00,  8'd13, 4'd3},   // R3 bit total
        {OP_RD,   4'b1000, 4'h5, 8'h00,  8'h00, 4'd3},   // R3 byte above width
        {OP_RD,   4'b1000, 4'h8, 8'h00,  8'd3,  4'd2},   // R2 error total
        {OP_RD,   4'b1000, 4'h9, 8'h00,  8'h00, 4'd3},
        {OP_WR,   4'b1000, 4'h0, 8'h00,  8'h00, 4'd3},
        {OP_IDLE, 4'b1100, 4'h0, 8'd4,   8'h00, 4'd3},
        {OP_WR,   4'b1000, 4'h0, 8'h01,  8'h00, 4'd3},
        {OP_IDLE, 4'b1000, 4'h0, 8'd1,   8'h00, 4'd3},
        {OP_RD,   4'b1000, 4'h4, 8'h00,  8'd4,  4'd3},   // R3 restart after capture
        {OP_RD,   4'b1000, 4'h8, 8'h00,  8'd0,  4'd3},
        {OP_WR,   4'b1000, 4'h0, 8'h00,  8'h00, 4'd4},
        {OP_IDLE, 4'b1100, 4'h0, 8'd7,   8'h00, 4'd4},
        {OP_IDLE, 4'b1101, 4'h0, 8'd3,   8'h00, 4'd4},   // R4 pin held three cycles
        {OP_IDLE, 4'b1000, 4'h0, 8'd1,   8'h00, 4'd4},
        {OP_RD,   4'b1000, 4'h4, 8'h00,  8'd7,  4'd4},   // R4 single capture
        {OP_IDLE, 4'b1001, 4'h0, 8'd1,   8'h00, 4'd4},
        {OP_IDLE, 4'b1000, 4'h0, 8'd1,   8'h00, 4'd4},
        {OP_RD,   4'b1000, 4'h4, 8'h00,  8'd3,  4'd4},   // R4 bits counted in edge cycle
        {OP_WR,   4'b1000, 4'h4, 8'hAA,  8'h00, 4'd10},  // R10 write to read-only
        {OP_RD,   4'b1000, 4'h4, 8'h00,  8'd3,  4'd10},
        {OP_WR,   4'b1000, 4'h1, 8'h5A,  8'h00, 4'd9},   // R9 mask write
        {OP_RD,   4'b1000, 4'h1, 8'h00,  8'h5A, 4'd9},
        {OP_RD,   4'b1000, 4'h0, 8'h00,  8'h00, 4'd3},
        {OP_RD,   4'b1000, 4'h3, 8'h00,  8'h00, 4'd10},  // R10 unused address
        {OP_RD,   4'b1000, 4'h2, 8'h00,  8'h19, 4'd7},   // R7 los, err, sync
        {OP_RD,   4'b1000, 4'h2, 8'h00,  8'h01, 4'd8}    // R8 cleared by read
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0, bit_vld = 1'b0, err_pulse = 1'b0;
    logic       all_ones = 1'b0, all_zeros = 1'b0, latch_pin = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_addr = 4'h0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       irq_n;

    int  nvec = 0;
    int  nbad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    ber_meas_top #(.CNT_W(TB_CNT_W)) dut_i (
        .clk(clk), .rst(rst), .sync_in(sync_in), .bit_vld(bit_vld),
        .err_pulse(err_pulse), .all_ones(all_ones), .all_zeros(all_zeros),
        .latch_pin(latch_pin), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_n(irq_n)
    );

    task automatic set_flags(input logic [3:0] f);
        {sync_in, bit_vld, err_pulse, latch_pin} = f;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input int r);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        nvec++;
        if (host_rdata !== e) begin
            nbad++;
            $display("FAIL R%0d read addr %0h actual %02h expected %02h", r, a, host_rdata, e);
        end
        @(negedge clk);
    endtask

    task automatic irq_chk(input logic e, input int r);
        @(negedge clk);
        nvec++;
        if (irq_n !== e) begin
            nbad++;
            $display("FAIL R%0d irq_n actual %0b expected %0b", r, irq_n, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL R1 watchdog actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nvec++;
        if (host_rdata !== 8'h00 || irq_n !== 1'b1) begin
            nbad++;
            $display("FAIL R1 after reset actual rdata=%02h irq_n=%0b expected 00/1", host_rdata, irq_n);
        end
        rd_chk(4'h4, 8'h00, 1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            set_flags(v[27:24]);
            case (v[29:28])
                OP_IDLE: idle(int'(v[19:12]));
                OP_WR:   wr(v[23:20], v[19:12]);
                default: rd_chk(v[23:20], v[11:4], int'(v[3:0]));
            endcase
        end

        // R5 bit counter wrap
        set_flags(4'b1100); idle(256);
        idle(5);
        set_flags(4'b1001); idle(1);
        set_flags(4'b1000); idle(1);
        rd_chk(4'h4, 8'd5, 5);
        rd_chk(4'h2, 8'h05, 5);
        rd_chk(4'h2, 8'h01, 8);
        // R5 error counter wrap, R6 error flag
        set_flags(4'b1110); idle(256);
        set_flags(4'b1000); idle(1);
        rd_chk(4'h2, 8'h0F, 5);
        rd_chk(4'h2, 8'h01, 6);

        // R8 condition bits persist while present
        all_ones = 1'b1; idle(2);
        rd_chk(4'h2, 8'h41, 7);
        rd_chk(4'h2, 8'h41, 8);
        all_ones = 1'b0;
        rd_chk(4'h2, 8'h41, 8);
        rd_chk(4'h2, 8'h01, 8);
        all_zeros = 1'b1; idle(2);
        all_zeros = 1'b0;
        rd_chk(4'h2, 8'h21, 7);
        rd_chk(4'h2, 8'h01, 8);

        // R7/R8 loss of lock
        set_flags(4'b0000); idle(3);
        rd_chk(4'h2, 8'h10, 7);
        rd_chk(4'h2, 8'h10, 8);
        set_flags(4'b1000);
        rd_chk(4'h2, 8'h11, 8);
        rd_chk(4'h2, 8'h01, 8);

        // R8 error in the read cycle survives the clear
        host_addr = 4'h2; host_rd = 1'b1;
        set_flags(4'b1110);
        @(negedge clk);
        host_rd = 1'b0;
        set_flags(4'b1000);
        nvec++;
        if (host_rdata !== 8'h01) begin
            nbad++;
            $display("FAIL R8 race read actual %02h expected 01", host_rdata);
        end
        @(negedge clk);
        rd_chk(4'h2, 8'h09, 8);
        rd_chk(4'h2, 8'h01, 8);

        // R9 interrupt masking
        irq_chk(1'b1, 9);
        wr(4'h1, 8'h01);
        irq_chk(1'b0, 9);
        set_flags(4'b0000);
        irq_chk(1'b1, 9);
        set_flags(4'b1000);
        wr(4'h1, 8'h10);
        irq_chk(1'b0, 9);
        wr(4'h1, 8'h00);
        irq_chk(1'b1, 9);
        rd_chk(4'h2, 8'h11, 8);

        // R1 reset in mid-run
        wr(4'h1, 8'h7F);
        rst = 1'b1; idle(2);
        rst = 1'b0;
        nvec++;
        if (host_rdata !== 8'h00 || irq_n !== 1'b1) begin
            nbad++;
            $display("FAIL R1 mid reset actual rdata=%02h irq_n=%0b expected 00/1", host_rdata, irq_n);
        end
        rd_chk(4'h1, 8'h00, 1);
        rd_chk(4'h4, 8'h00, 1);
        rd_chk(4'h8, 8'h00, 1);
        rd_chk(4'h2, 8'h01, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule